// File: doc/BRIEF.md
# External Bus Tenure Controller

This block decides when a processor asks for a shared external bus, when it takes the bus over and when it hands the bus back. It uses three wires. The request line goes out to an external arbiter. The grant line comes back from that arbiter. The busy line is active-low and shared by every master; each master drives it while it owns the bus, and an external pull-up holds it high when nobody drives it.

On the processor side the block takes four things: an indication that an external access is pending, a strobe that marks the end of each bus cycle, a software bit that forces the request on, and an enable that routes grant and busy through two-stage synchronizers. Stop and wait mode inputs limit what the request line does while the core is idle.

Once the block owns the bus it keeps the busy line low for as long as the grant stays on, even when no traffic is left. This is bus parking. When the grant goes away, the block gives the bus back at a cycle boundary. To release the busy line it drives it high for one clock and then stops driving it. A status output tells the core when it is bus master.

Top module: `bus_tenure_ctrl`

## Requirements
- R1: While `rst_n` is low and at the first sample after reset, `req_o` is 0, `master_o` is 0 and `busy_n_oe` is 0. The block starts as a bus slave.
- R2: When stop and wait are both low and `hold_req` is 0, `req_o` equals the value `xfer_pend` had one clock earlier. This holds whether or not the block is master.
- R3: When stop and wait are both low and `hold_req` is 1, `req_o` is 1 one clock later, whatever `xfer_pend` is.
- R4: When `stop_i` or `wait_i` is 1 and `hold_req` is 0, `req_o` is 0 one clock later. When one of them is 1 and `hold_req` is 1, `req_o` keeps its previous value.
- R5: The block takes the bus (`busy_n_oe`=1, `busy_n_o`=0) only in the clock after both of these held: `req_o` was 1 with an effective grant, and the effective busy was deasserted. While another master holds `busy_n_i` low, the block does not take the bus.
- R6: While master and while the effective grant stays 1, the block keeps driving `busy_n_o` low, even if `xfer_pend` and `req_o` are 0 (parking).
- R7: When the effective grant is 0 and the block is master, it keeps the bus while `xfer_pend` is 1 and `cyc_done` is 0. It starts the release in the clock after `cyc_done` is 1, or after `xfer_pend` is 0.
- R8: A release drives `busy_n_o` high with `busy_n_oe`=1 for exactly one clock. After that, `busy_n_oe` is 0.
- R9: `master_o` rises one clock after the block first drives the busy line low. It falls one clock after the one-clock high drive starts.
- R10: With `async_arb`=0, grant and busy act in the same clock. With `async_arb`=1, each passes through a two-flop synchronizer, so a grant applied to a free bus is taken over on the third clock.
- R11: With `async_arb`=1, after the synchronized grant falls, a new grant is ignored for `GAP_CYC` clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| xfer_pend | input | 1 | An external-bus access is pending |
| cyc_done | input | 1 | The current bus cycle ends in this clock |
| hold_req | input | 1 | Software bit that forces the request on |
| async_arb | input | 1 | Routes grant and busy through synchronizers |
| stop_i | input | 1 | Core is in stop mode |
| wait_i | input | 1 | Core is in wait mode |
| gnt_i | input | 1 | Grant from the arbiter, active high |
| busy_n_i | input | 1 | Sampled level of the shared busy line, active low |
| req_o | output | 1 | Bus request to the arbiter, active high |
| busy_n_o | output | 1 | Value driven onto the busy line |
| busy_n_oe | output | 1 | Output enable for the busy line |
| master_o | output | 1 | Block is bus master |

## Verification
The assertions are checked on every cycle. They cover the following: the forced request, the request drop in low-power mode, that the bus is never taken while the busy line is held, that the bus stays parked while the grant holds, that a bus cycle is never cut while it runs, the single clock of high drive, and the grant lockout right after the synchronized grant falls. Other behaviours show only in the bench scenarios, because they depend on exact timing. These are the latency from pending access to request, the exact clock at which the bus is taken in each mode, the delay of `master_o`, and the lockout window lasting the full `GAP_CYC` clocks.

// File: rtl/bus_tenure_pkg.sv
`timescale 1ns/1ps
// Shared types for the external bus tenure controller.
package bus_tenure_pkg;
    // Ownership phase of the external bus.
    typedef enum logic [1:0] {
        TN_SLAVE = 2'd0,   // not driving the busy line
        TN_OWN   = 2'd1,   // driving busy low
        TN_LETGO = 2'd2    // one-clock high drive before tri-state
    } tenure_e;
endpackage

// File: rtl/arb_in_cond.sv
`timescale 1ns/1ps
// Conditions the grant and busy inputs.
// In direct mode both pass straight through.
// In async mode each goes through a SYNC_STAGES-flop synchronizer, and a
// falling synchronized grant starts a GAP_CYC-clock window in which a new
// grant is ignored.
// Assumes: SYNC_STAGES >= 2, GAP_CYC >= 1, async_en changes only while the bus is idle.
module arb_in_cond #(
    parameter int SYNC_STAGES = 2,
    parameter int GAP_CYC     = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_en,
    input  logic gnt_i,
    input  logic busy_n_i,
    output logic gnt_eff,
    output logic busy_eff
);
    localparam int CW = $clog2(GAP_CYC + 1);

    logic [SYNC_STAGES-1:0] gnt_ff;
    logic [SYNC_STAGES-1:0] busy_ff;
    logic                   gnt_s;
    logic                   gnt_sd;
    logic                   gnt_fall;
    logic [CW-1:0]          gap_cnt;

    // Synchronizer chains; busy is stored active-high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gnt_ff  <= '0;
            busy_ff <= '0;
        end else begin
            gnt_ff  <= {gnt_ff[SYNC_STAGES-2:0], gnt_i};
            busy_ff <= {busy_ff[SYNC_STAGES-2:0], ~busy_n_i};
        end
    end

    assign gnt_s    = gnt_ff[SYNC_STAGES-1];
    assign gnt_fall = gnt_sd & ~gnt_s;

    // Delayed synchronized grant, used for fall detection.
    always_ff @(posedge clk) begin
        if (!rst_n) gnt_sd <= 1'b0;
        else        gnt_sd <= gnt_s;
    end

    // Re-grant lockout counter, loaded on a synchronized grant fall.
    always_ff @(posedge clk) begin
        if (!rst_n)                     gap_cnt <= '0;
        else if (async_en && gnt_fall)  gap_cnt <= CW'(GAP_CYC);
        else if (gap_cnt != '0)         gap_cnt <= gap_cnt - 1'b1;
    end

    // Select direct or synchronized view of the arbitration wires.
    always_comb begin
        if (async_en) begin
            gnt_eff  = gnt_s && (gap_cnt == '0);
            busy_eff = busy_ff[SYNC_STAGES-1];
        end else begin
            gnt_eff  = gnt_i;
            busy_eff = ~busy_n_i;
        end
    end

    // R11: grant is blocked in the clock after a synchronized fall
    p_regrant_gap_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (async_en && gnt_fall) |=> !gnt_eff);
endmodule

// File: rtl/bus_req_gen.sv
`timescale 1ns/1ps
// Registers the bus request from pending external accesses and the
// software hold bit.
// In stop or wait mode the request is dropped, unless the hold bit
// keeps the last value.
// Assumes: xfer_pend reflects external-bus accesses only.
module bus_req_gen (
    input  logic clk,
    input  logic rst_n,
    input  logic xfer_pend,
    input  logic hold_req,
    input  logic stop_i,
    input  logic wait_i,
    output logic req_o
);
    logic idle_mode;
    assign idle_mode = stop_i | wait_i;

    // Request register with low-power handling.
    always_ff @(posedge clk) begin
        if (!rst_n)         req_o <= 1'b0;
        else if (idle_mode) req_o <= hold_req ? req_o : 1'b0;
        else                req_o <= xfer_pend | hold_req;
    end

    // R3: hold bit forces the request outside low-power modes
    p_hold_forces_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_req && !idle_mode) |=> req_o);
    // R4: low-power mode without hold drops the request
    p_lowpwr_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_mode && !hold_req) |=> !req_o);
endmodule

// File: rtl/tenure_fsm.sv
`timescale 1ns/1ps
// Ownership state machine.
// It claims the busy line once the request has a grant and the bus is
// free. It parks while the grant holds. After the grant is removed it
// releases at a cycle boundary, driving busy high for one clock and then
// tri-stating it.
// Assumes: cyc_done is a one-clock strobe at the end of each bus cycle.
module tenure_fsm
    import bus_tenure_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_i,
    input  logic gnt_eff,
    input  logic busy_eff,
    input  logic xfer_pend,
    input  logic cyc_done,
    output logic busy_n_o,
    output logic busy_n_oe,
    output logic master_o
);
    tenure_e state_q, state_d;

    // Next-state selection.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TN_SLAVE: if (req_i && gnt_eff && !busy_eff) state_d = TN_OWN;
            TN_OWN:   if (!gnt_eff && (cyc_done || !xfer_pend)) state_d = TN_LETGO;
            TN_LETGO: state_d = TN_SLAVE;
            default:  state_d = TN_SLAVE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= TN_SLAVE;
        else        state_q <= state_d;
    end

    // Master flag lags the busy drive by one clock at both ends.
    always_ff @(posedge clk) begin
        if (!rst_n) master_o <= 1'b0;
        else        master_o <= (state_q == TN_OWN);
    end

    // Busy pin drive: low while owning, high for the release clock.
    assign busy_n_oe = (state_q != TN_SLAVE);
    assign busy_n_o  = (state_q == TN_LETGO);

    // R5: never claim while the busy line is held by another master
    p_no_claim_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == TN_SLAVE && busy_eff) |=> (state_q != TN_OWN));
    // R6: parked ownership holds while the grant stays
    p_park_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == TN_OWN && gnt_eff) |=> (state_q == TN_OWN));
    // R7: no release in the middle of a running cycle
    p_cycle_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == TN_OWN && xfer_pend && !cyc_done) |=> (state_q == TN_OWN));
    // R8: the high drive lasts exactly one clock
    p_pullup_once_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_n_oe && busy_n_o) |=> !busy_n_oe);
    // R9: master status implies the block is driving the busy line
    p_status_drive_r9: assert property (@(posedge clk) disable iff (!rst_n)
        master_o |-> busy_n_oe);
endmodule

// File: rtl/bus_tenure_ctrl.sv
`timescale 1ns/1ps
// Top of the external bus tenure controller.
// It joins input conditioning, request generation and the ownership
// state machine. The busy line is split into a value, an enable and a sample.
// Assumes: the board has an external pull-up on the busy line.
module bus_tenure_ctrl #(
    parameter int SYNC_STAGES = 2,
    parameter int GAP_CYC     = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic xfer_pend,
    input  logic cyc_done,
    input  logic hold_req,
    input  logic async_arb,
    input  logic stop_i,
    input  logic wait_i,
    input  logic gnt_i,
    input  logic busy_n_i,
    output logic req_o,
    output logic busy_n_o,
    output logic busy_n_oe,
    output logic master_o
);
    logic gnt_eff;
    logic busy_eff;

    arb_in_cond #(.SYNC_STAGES(SYNC_STAGES), .GAP_CYC(GAP_CYC)) u_cond (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_en (async_arb),
        .gnt_i    (gnt_i),
        .busy_n_i (busy_n_i),
        .gnt_eff  (gnt_eff),
        .busy_eff (busy_eff)
    );

    bus_req_gen u_req (
        .clk       (clk),
        .rst_n     (rst_n),
        .xfer_pend (xfer_pend),
        .hold_req  (hold_req),
        .stop_i    (stop_i),
        .wait_i    (wait_i),
        .req_o     (req_o)
    );

    tenure_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_i     (req_o),
        .gnt_eff   (gnt_eff),
        .busy_eff  (busy_eff),
        .xfer_pend (xfer_pend),
        .cyc_done  (cyc_done),
        .busy_n_o  (busy_n_o),
        .busy_n_oe (busy_n_oe),
        .master_o  (master_o)
    );

    // R1: reset leaves the block a non-requesting slave
    p_reset_slave_r1: assert property (@(posedge clk)
        !rst_n |=> (!req_o && !master_o && !busy_n_oe));
endmodule

// File: tb/bus_tenure_ctrl_tb.sv
`timescale 1ns/1ps
module bus_tenure_ctrl_tb;
    localparam int GAP = 4;
    localparam logic [3:0] M_REQ = 4'b1000, M_MST = 4'b0100,
                           M_OE = 4'b0010, M_BO = 4'b0001;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic xfer_pend = 0, cyc_done = 0, hold_req = 0, async_arb = 0;
    logic stop_i = 0, wait_i = 0, gnt_i = 0, ext_busy_n = 1;
    logic busy_n_i, req_o, busy_n_o, busy_n_oe, master_o;

    always #4 clk = ~clk;

    // Shared busy line: our drive, or the other master / pull-up.
    assign busy_n_i = busy_n_oe ? busy_n_o : ext_busy_n;

    bus_tenure_ctrl #(.SYNC_STAGES(2), .GAP_CYC(GAP)) u_dut (
        .clk(clk), .rst_n(rst_n), .xfer_pend(xfer_pend), .cyc_done(cyc_done),
        .hold_req(hold_req), .async_arb(async_arb), .stop_i(stop_i),
        .wait_i(wait_i), .gnt_i(gnt_i), .busy_n_i(busy_n_i), .req_o(req_o),
        .busy_n_o(busy_n_o), .busy_n_oe(busy_n_oe), .master_o(master_o)
    );

    typedef struct {
        int         at;
        logic [3:0] mask;
        logic [3:0] val;
        string      tag;
    } exp_t;

    exp_t sb_q[$];
    int   cyc = 0;
    int   n_run = 0;
    int   n_fail = 0;
    bit   done = 0;

    // Driver side: queue an expectation dly rising edges ahead.
    task automatic expect_out(input int dly, input logic [3:0] mask,
                              input logic [3:0] val, input string tag);
        exp_t e;
        e.at = cyc + dly; e.mask = mask; e.val = val; e.tag = tag;
        sb_q.push_back(e);
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Monitor: after each rising edge, compare the due expectations.
    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            #2;
            for (int i = 0; i < sb_q.size(); ) begin
                if (sb_q[i].at == cyc) begin
                    logic [3:0] act;
                    act = {req_o, master_o, busy_n_oe, busy_n_o};
                    n_run++;
                    if ((act & sb_q[i].mask) !== (sb_q[i].val & sb_q[i].mask)) begin
                        n_fail++;
                        $display("FAIL %s cyc %0d: actual %b expected %b (mask %b)",
                                 sb_q[i].tag, cyc, act, sb_q[i].val, sb_q[i].mask);
                    end
                    sb_q.delete(i);
                end else begin
                    i++;
                end
            end
        end
    end

    // Watchdog.
    initial begin
        #(8 * 20000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        tick(1);
        expect_out(1, M_REQ | M_MST | M_OE, 4'b0000, "R1 in reset");
        tick(3);
        rst_n = 1'b1;
        expect_out(1, M_REQ | M_MST | M_OE, 4'b0000, "R1 after reset");
        tick(2);

        // R2: request follows pending access
        xfer_pend = 1; expect_out(1, M_REQ, 4'b1000, "R2 rise"); tick(1);
        xfer_pend = 0; expect_out(1, M_REQ, 4'b0000, "R2 fall"); tick(1);

        // R3: hold bit forces request
        hold_req = 1; expect_out(1, M_REQ, 4'b1000, "R3 hold"); tick(2);
        hold_req = 0; tick(2);

        // R4: low-power modes
        xfer_pend = 1; stop_i = 1; expect_out(1, M_REQ, 4'b0000, "R4 stop drop"); tick(1);
        stop_i = 0; wait_i = 1; expect_out(1, M_REQ, 4'b0000, "R4 wait drop"); tick(1);
        wait_i = 0; expect_out(1, M_REQ, 4'b1000, "R4 exit"); tick(1);
        xfer_pend = 0; tick(2);
        stop_i = 1; hold_req = 1; xfer_pend = 1;
        expect_out(1, M_REQ, 4'b0000, "R4 keep last low");
        expect_out(2, M_REQ, 4'b0000, "R4 keep last low 2");
        tick(2);
        stop_i = 0; hold_req = 0; xfer_pend = 0; tick(2);

        // R5: no claim while another master holds busy
        xfer_pend = 1; gnt_i = 1; ext_busy_n = 0;
        expect_out(2, M_OE, 4'b0000, "R5 held off");
        tick(3);
        ext_busy_n = 1;
        expect_out(1, M_OE | M_BO | M_MST, 4'b0010, "R5 claim R9 flag lag");
        expect_out(2, M_MST, 4'b0100, "R9 flag set");
        tick(2);

        // R2 while master, then R6 parking
        xfer_pend = 0;
        expect_out(1, M_REQ | M_MST, 4'b0100, "R2 drop while master");
        expect_out(4, M_MST | M_OE | M_BO, 4'b0110, "R6 parked");
        tick(4);

        // R7 idle release, R8 pull-up, R9 flag drop
        gnt_i = 0;
        expect_out(1, M_MST | M_OE | M_BO, 4'b0111, "R8 drive high");
        expect_out(2, M_MST | M_OE, 4'b0000, "R8 tristate R9 drop");
        tick(2);

        // Reacquire, then R7 release at cycle boundary
        xfer_pend = 1; gnt_i = 1;
        expect_out(2, M_OE | M_BO, 4'b0010, "R5 reclaim");
        tick(3);
        gnt_i = 0;
        expect_out(1, M_OE | M_BO, 4'b0010, "R7 mid-cycle hold");
        expect_out(2, M_OE | M_BO, 4'b0010, "R7 mid-cycle hold 2");
        tick(2);
        cyc_done = 1; expect_out(1, M_OE | M_BO, 4'b0011, "R7 release at end"); tick(1);
        cyc_done = 0; expect_out(1, M_OE, 4'b0000, "R8 tristate"); tick(1);
        xfer_pend = 0; tick(1);

        // R10: synchronized mode latency
        async_arb = 1; hold_req = 1; tick(4);
        gnt_i = 1;
        expect_out(2, M_OE, 4'b0000, "R10 not yet");
        expect_out(3, M_OE | M_BO, 4'b0010, "R10 claim third clock");
        tick(4);

        // R11: re-grant lockout
        gnt_i = 0; tick(1);
        gnt_i = 1;
        expect_out(2, M_OE | M_BO, 4'b0011, "R8 async release");
        expect_out(5, M_OE, 4'b0000, "R11 locked out");
        expect_out(6, M_OE, 4'b0000, "R11 locked out end");
        expect_out(7, M_OE | M_BO, 4'b0010, "R11 claim after gap");
        tick(9);

        while (sb_q.size() != 0) tick(1);
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule